// File: doc/BRIEF.md
# Eye-Scan Offset Sweep Sequencer

This block walks an offset sampler through a three-dimensional grid of scan points. For every point it places a vertical threshold code and a horizontal timing code on its outputs. It also drives a one-hot mask that picks one bit position inside a history window of `WIN` bits. The horizontal code moves the sampling instant earlier or later around the eye centre. The vertical code moves the decision threshold. The receiver keeps taking in data normally while the codes change.

Each point runs in a fixed order. The sequencer waits a configurable number of settle cycles after the codes change. It then pulses a start request to an external fixed-length hit counter and waits for that counter's done strobe. Finally it presents the point's coordinates together with the captured count on a valid/ready result port.

The vertical code is the fastest loop, the horizontal code is the middle loop and the bit position is the slowest loop. Stepping the bit position lets the scan cover several consecutive bits of a repeating waveform rather than one statistical bit period. A sweep starts on a `sweep_go` request while idle. It ends with a one-cycle `sweep_done` pulse.

Top module: `scan_sweep_seq`

## Requirements
- R1: While reset is asserted, and after it is released, the outputs are as follows until the first `sweep_go`: `res_valid`, `cnt_start` and `sweep_done` are 0, `ofs_x` and `ofs_y` are 0, and `bit_mask` is 1. A reset asserted in the middle of a sweep returns the block to this state.
- R2: Scan points are visited in a fixed order. `ofs_y` steps from 0 to 2^Y_W-1. Each time it wraps back to 0, `ofs_x` steps by one, from 0 to 2^X_W-1. Each time `ofs_x` wraps, the bit index steps by one. The bit index starts at `cfg_bit_first` and the last point is at bit index `cfg_bit_last`. A sweep therefore produces 2^(X_W+Y_W) results per bit index.
- R3: `bit_mask` is one-hot. Bit i of the mask is 1 exactly when the current bit index equals i.
- R4: `cnt_start` goes high for exactly one cycle, `cfg_settle`+1 cycles after the scan point's offsets are loaded. For the first point the load happens on the clock edge that accepts `sweep_go`.
- R5: `ofs_x`, `ofs_y` and `bit_mask` stay constant from the start request until the point's result is accepted.
- R6: `cnt_done` is ignored except while the block is waiting for the counter. The reported count is the `cnt_value` present in the cycle `cnt_done` is seen during that wait.
- R7: A result is presented as `res_bit`, `res_x`, `res_y` and `res_count` with `res_valid`. While `res_ready` is low, all of these stay stable and no new start is issued.
- R8: `sweep_done` is high for one cycle, in the cycle after the last result is accepted. `res_valid` is low in that cycle.
- R9: `sweep_go` and configuration changes have no effect while a sweep is running. A new sweep begins only on a `sweep_go` seen while idle.
- R10: The bit index advances modulo `WIN`. A `cfg_bit_last` below `cfg_bit_first` makes the sweep pass through WIN-1 and continue from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sweep_go | input | 1 | Request to begin a sweep (taken only when idle) |
| cfg_settle | input | SET_W | Settle cycles after an offset change |
| cfg_bit_first | input | IDX_W | First bit index of the sweep |
| cfg_bit_last | input | IDX_W | Last bit index of the sweep |
| ofs_x | output | X_W | Horizontal timing offset code |
| ofs_y | output | Y_W | Vertical threshold offset code |
| bit_mask | output | WIN | One-hot bit-position selector |
| cnt_start | output | 1 | One-cycle start request to the hit counter |
| cnt_done | input | 1 | Counter finished strobe |
| cnt_value | input | CNT_W | Counter result, valid with `cnt_done` |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result accepted when high with `res_valid` |
| res_bit | output | IDX_W | Bit index of the result |
| res_x | output | X_W | Horizontal code of the result |
| res_y | output | Y_W | Vertical code of the result |
| res_count | output | CNT_W | Captured count |
| sweep_done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The hardest conditions to reach from the ports are a stray counter done strobe while the block is still settling, and a second `sweep_go` in the middle of a sweep. The bench raises a done strobe with a poison value during the settle window of the first point. It checks that the first result still carries the value its own counter model returns later. It also pulses `sweep_go` with a different first bit index partway through a sweep and checks that the result order continues unchanged. Long bit-index wraps and random result stalls come from the stimulus table. A reset forced in the middle of a sweep shows that the block returns to idle and recovers.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_FIRE   = 3'd2,
    ST_WAIT   = 3'd3,
    ST_EMIT   = 3'd4
  } seq_state_t;

endpackage

// File: rtl/scan_axis.sv
// One coordinate of the sweep: loadable, steps by one, wraps at MAXV,
// flags when it sits on its end value.
module scan_axis #(
  parameter int W    = 3,
  parameter int MAXV = (1 << W) - 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic [W-1:0] end_val,
  output logic [W-1:0] val,
  output logic         at_end
);

  logic [W-1:0] val_d;
  logic         wrap;

  assign wrap   = (val == W'(MAXV));
  assign at_end = (val == end_val);

  always_comb begin
    val_d = val;
    if (load)      val_d = load_val;
    else if (step) val_d = wrap ? '0 : val + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            val <= '0;
    else if (load || step) val <= val_d;
  end

  AST_AXIS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !wrap) |=> (val == $past(val) + 1'b1)); // R2

  AST_AXIS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && wrap) |=> (val == '0)); // R10

endmodule

// File: rtl/scan_settle.sv
// Down-counter that delays the counter start after each offset change.
module scan_settle #(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SET_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);

  logic [SET_W-1:0] cnt_q;
  logic [SET_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load || (run && !expired);

  always_comb begin
    cnt_d = cnt_q;
    if (load)                 cnt_d = load_val;
    else if (run && !expired) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_SETTLE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4

endmodule

// File: rtl/scan_mask.sv
// Decodes the bit index into a one-hot window selector.
module scan_mask #(
  parameter int WIN   = 32,
  parameter int IDX_W = $clog2(WIN)
) (
  input  logic [IDX_W-1:0] idx,
  output logic [WIN-1:0]   mask
);

  for (genvar i = 0; i < WIN; i++) begin : g_dec
    assign mask[i] = (idx == IDX_W'(i));
  end

endmodule

// File: rtl/scan_sweep_seq.sv
module scan_sweep_seq
  import scan_pkg::*;
#(
  parameter int  X_W   = 3,
  parameter int  Y_W   = 2,
  parameter int  CNT_W = 16,
  parameter int  SET_W = 8,
  parameter int  WIN   = 32,
  localparam int IDX_W = $clog2(WIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sweep_go,
  input  logic [SET_W-1:0] cfg_settle,
  input  logic [IDX_W-1:0] cfg_bit_first,
  input  logic [IDX_W-1:0] cfg_bit_last,
  output logic [X_W-1:0]   ofs_x,
  output logic [Y_W-1:0]   ofs_y,
  output logic [WIN-1:0]   bit_mask,
  output logic             cnt_start,
  input  logic             cnt_done,
  input  logic [CNT_W-1:0] cnt_value,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [IDX_W-1:0] res_bit,
  output logic [X_W-1:0]   res_x,
  output logic [Y_W-1:0]   res_y,
  output logic [CNT_W-1:0] res_count,
  output logic             sweep_done
);

  localparam logic [X_W-1:0] X_END = '1;
  localparam logic [Y_W-1:0] Y_END = '1;

  // reset: asynchronous assert, synchronous release
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  seq_state_t       st_q, st_d;
  logic [IDX_W-1:0] last_q;
  logic [SET_W-1:0] settle_q;
  logic [CNT_W-1:0] count_q;
  logic             done_q;

  logic go_take, accept, adv, fin, cap;
  logic y_end, x_end, b_end, last_pt;
  logic settle_exp;
  logic [IDX_W-1:0] bidx;

  assign go_take = (st_q == ST_IDLE) && sweep_go;
  assign accept  = (st_q == ST_EMIT) && res_ready;
  assign last_pt = y_end && x_end && b_end;
  assign adv     = accept && !last_pt;
  assign fin     = accept && last_pt;
  assign cap     = (st_q == ST_WAIT) && cnt_done;

  // coordinate chain: y fastest, then x, then bit index
  scan_axis #(.W(Y_W)) u_ay (
    .clk(clk), .rst_n(rst_s), .load(go_take), .load_val('0),
    .step(adv), .end_val(Y_END), .val(ofs_y), .at_end(y_end));

  scan_axis #(.W(X_W)) u_ax (
    .clk(clk), .rst_n(rst_s), .load(go_take), .load_val('0),
    .step(adv && y_end), .end_val(X_END), .val(ofs_x), .at_end(x_end));

  scan_axis #(.W(IDX_W), .MAXV(WIN - 1)) u_ab (
    .clk(clk), .rst_n(rst_s), .load(go_take), .load_val(cfg_bit_first),
    .step(adv && y_end && x_end), .end_val(last_q), .val(bidx), .at_end(b_end));

  scan_settle #(.SET_W(SET_W)) u_settle (
    .clk(clk), .rst_n(rst_s), .load(go_take || adv),
    .load_val(go_take ? cfg_settle : settle_q),
    .run(st_q == ST_SETTLE), .expired(settle_exp));

  scan_mask #(.WIN(WIN), .IDX_W(IDX_W)) u_mask (.idx(bidx), .mask(bit_mask));

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (sweep_go)   st_d = ST_SETTLE;
      ST_SETTLE: if (settle_exp) st_d = ST_FIRE;
      ST_FIRE:                   st_d = ST_WAIT;
      ST_WAIT:   if (cnt_done)   st_d = ST_EMIT;
      ST_EMIT:   if (res_ready)  st_d = last_pt ? ST_IDLE : ST_SETTLE;
      default:                   st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      last_q   <= '0;
      settle_q <= '0;
    end else if (go_take) begin
      last_q   <= cfg_bit_last;
      settle_q <= cfg_settle;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)   count_q <= '0;
    else if (cap) count_q <= cnt_value;
  end

  assign cnt_start  = (st_q == ST_FIRE);
  assign res_valid  = (st_q == ST_EMIT);
  assign res_bit    = bidx;
  assign res_x      = ofs_x;
  assign res_y      = ofs_y;
  assign res_count  = count_q;
  assign sweep_done = done_q;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_s)
    cnt_start |=> !cnt_start); // R4

  AST_OFS_FROZEN: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_WAIT) |-> ($stable(ofs_x) && $stable(ofs_y) && $stable(bit_mask))); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_count) && $stable(res_x)
                                   && $stable(res_y) && $stable(res_bit))); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_s)
    sweep_done |=> !sweep_done); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_s)
    sweep_done |-> !res_valid); // R8

  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(bit_mask) && (bit_mask != '0)); // R3

endmodule

// File: tb/sim_scan_sweep_seq.sv
module sim_scan_sweep_seq;

  localparam int XW = 3;
  localparam int YW = 2;
  localparam int CW = 16;
  localparam int SW = 8;
  localparam int WN = 32;
  localparam int IW = 5;
  localparam int NX = 1 << XW;
  localparam int NY = 1 << YW;

  // stimulus table: {settle[15:12], first[11:7], last[6:2], ready_mode[1:0]}
  localparam logic [15:0] VEC [4] = '{
    {4'd0, 5'd0,  5'd0,  2'd0},
    {4'd3, 5'd4,  5'd6,  2'd1},
    {4'd1, 5'd30, 5'd1,  2'd2},
    {4'd6, 5'd31, 5'd31, 2'd3}
  };

  logic          clk, rst_n, sweep_go;
  logic [SW-1:0] cfg_settle;
  logic [IW-1:0] cfg_bit_first, cfg_bit_last;
  logic [XW-1:0] ofs_x, res_x;
  logic [YW-1:0] ofs_y, res_y;
  logic [WN-1:0] bit_mask;
  logic          cnt_start, cnt_done, res_valid, res_ready, sweep_done;
  logic [CW-1:0] cnt_value, res_count;
  logic [IW-1:0] res_bit;

  logic          mdl_done, inj_done;
  logic [CW-1:0] mdl_val, inj_val;

  int total = 0, bad = 0;
  int eb, ex, ey, acc, exp_total, settle_cur, rmode, done_cnt;
  logic go_real;
  logic finished = 1'b0;

  assign cnt_done  = mdl_done | inj_done;
  assign cnt_value = inj_done ? inj_val : mdl_val;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  scan_sweep_seq u0 (
    .clk(clk), .rst_n(rst_n), .sweep_go(sweep_go), .cfg_settle(cfg_settle),
    .cfg_bit_first(cfg_bit_first), .cfg_bit_last(cfg_bit_last),
    .ofs_x(ofs_x), .ofs_y(ofs_y), .bit_mask(bit_mask), .cnt_start(cnt_start),
    .cnt_done(cnt_done), .cnt_value(cnt_value), .res_valid(res_valid),
    .res_ready(res_ready), .res_bit(res_bit), .res_x(res_x), .res_y(res_y),
    .res_count(res_count), .sweep_done(sweep_done));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [CW-1:0] hitval(input int b, input int x, input int y);
    return CW'(b * 97 + x * 13 + y * 5 + 1000);
  endfunction

  function automatic int mpos(input logic [WN-1:0] m);
    int p = -1;
    if ($countones(m) == 1)
      for (int i = 0; i < WN; i++) if (m[i]) p = i;
    return p;
  endfunction

  // hit counter model: done two cycles after start, garbage value otherwise
  initial begin
    mdl_done = 1'b0;
    mdl_val  = 16'hBEEF;
    forever begin
      @(negedge clk);
      mdl_done = 1'b0;
      mdl_val  = 16'hBEEF;
      if (cnt_start) begin
        logic [CW-1:0] v;
        v = hitval(mpos(bit_mask), int'(ofs_x), int'(ofs_y));
        repeat (2) @(negedge clk);
        mdl_done = 1'b1;
        mdl_val  = v;
      end
    end
  end

  // result consumer
  logic [7:0] lfsr = 8'h5B;
  int         cyc = 0;
  logic       held = 1'b0;
  logic [IW+XW+YW+CW-1:0] held_pl;
  initial begin
    res_ready = 1'b0;
    forever begin
      logic rn;
      @(negedge clk);
      cyc++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (rmode)
        0: rn = 1'b1;
        1: rn = cyc[0];
        2: rn = lfsr[0];
        default: rn = (cyc % 4 == 3);
      endcase
      if (held && res_valid)
        chk({res_bit, res_x, res_y, res_count} == held_pl, "R7", "stalled payload",
            {res_bit, res_x, res_y, res_count}, held_pl);
      res_ready = rn;
      if (res_valid && rn) begin
        chk(res_bit == IW'(eb) && res_x == XW'(ex) && res_y == YW'(ey), "R2",
            "result coordinates", {res_bit, res_x, res_y}, {IW'(eb), XW'(ex), YW'(ey)});
        chk(res_count == hitval(eb, ex, ey), "R6", "result count", res_count,
            hitval(eb, ex, ey));
        acc++;
        ey++;
        if (ey == NY) begin
          ey = 0; ex++;
          if (ex == NX) begin ex = 0; eb = (eb + 1) % WN; end
        end
      end
      held    = res_valid && !rn;
      held_pl = {res_bit, res_x, res_y, res_count};
    end
  end

  // monitor: settle gap, start placement, done pulse
  initial begin
    int gap = 0;
    logic go_d = 1'b0;
    logic sd_d = 1'b0;
    logic [XW+YW+WN-1:0] prev = '0;
    done_cnt = 0;
    forever begin
      @(negedge clk);
      #1;
      if ({ofs_x, ofs_y, bit_mask} != prev || go_d) gap = 0;
      else gap++;
      prev = {ofs_x, ofs_y, bit_mask};
      go_d = sweep_go && go_real;
      if (cnt_start) begin
        chk(gap == settle_cur + 1, "R4", "start delay", gap, settle_cur + 1);
        chk(!res_valid, "R7", "start while result pending", res_valid, 0);
        chk(bit_mask == (32'h1 << eb), "R3", "mask at start", bit_mask, 32'h1 << eb);
        chk(ofs_x == XW'(ex) && ofs_y == YW'(ey), "R5", "offsets at start",
            {ofs_x, ofs_y}, {XW'(ex), YW'(ey)});
      end
      if (sweep_done) begin
        done_cnt++;
        chk(!sd_d, "R8", "done longer than one cycle", sd_d, 0);
        chk(!res_valid, "R8", "valid with done", res_valid, 0);
        chk(acc == exp_total, "R8", "results before done", acc, exp_total);
      end
      sd_d = sweep_done;
    end
  end

  task automatic run_sweep(input int st, input int first, input int last, input int mode,
                           input bit mid_go, input bit bad_done, input string tag);
    int d0;
    @(negedge clk);
    cfg_settle = SW'(st); cfg_bit_first = IW'(first); cfg_bit_last = IW'(last);
    rmode = mode; settle_cur = st;
    eb = first; ex = 0; ey = 0; acc = 0;
    exp_total = (((last - first) % WN + WN) % WN + 1) * NX * NY;
    d0 = done_cnt;
    go_real = 1'b1; sweep_go = 1'b1;
    @(negedge clk);
    sweep_go = 1'b0; go_real = 1'b0;
    if (bad_done) begin
      inj_done = 1'b1; inj_val = 16'hDEAD;   // R6 stray done while settling
      @(negedge clk);
      inj_done = 1'b0;
    end
    if (mid_go) begin
      repeat (40) @(negedge clk);
      cfg_bit_first = IW'(first + 9); cfg_settle = SW'(st + 2);
      sweep_go = 1'b1;                        // R9 ignored mid-sweep
      @(negedge clk);
      sweep_go = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    chk(acc == exp_total, tag, "point count", acc, exp_total);
    repeat (20) @(negedge clk);
    chk(done_cnt == d0 + 1 && !res_valid, "R9", "no restart after sweep",
        done_cnt, d0 + 1);
  endtask

  task automatic chk_idle(input string what);
    chk(!res_valid && !cnt_start && !sweep_done, "R1", {what, " strobes"},
        {res_valid, cnt_start, sweep_done}, 0);
    chk(ofs_x == '0 && ofs_y == '0 && bit_mask == 32'h1, "R1", {what, " offsets"},
        {ofs_x, ofs_y, bit_mask}, 32'h1);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sweep_go = 1'b0; go_real = 1'b0;
    cfg_settle = '0; cfg_bit_first = '0; cfg_bit_last = '0;
    inj_done = 1'b0; inj_val = '0;
    rmode = 0; settle_cur = 0; eb = 0; ex = 0; ey = 0; acc = 0; exp_total = 0;
    repeat (3) @(negedge clk);
    #1 chk_idle("in reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #1 chk_idle("after reset");

    // table-driven sweeps (R2, R3, R4, R7, R10)
    foreach (VEC[i]) begin
      run_sweep(int'(VEC[i][15:12]), int'(VEC[i][11:7]), int'(VEC[i][6:2]),
                int'(VEC[i][1:0]), 1'b0, 1'b0, (i == 2) ? "R10" : "R2");
    end

    // stray done during settle, go while busy (R6, R9)
    run_sweep(5, 2, 3, 2, 1'b1, 1'b1, "R9");

    // reset in the middle of a sweep, then recovery (R1)
    @(negedge clk);
    cfg_settle = 8'd2; cfg_bit_first = 5'd7; cfg_bit_last = 5'd8; rmode = 1;
    settle_cur = 2; eb = 7; ex = 0; ey = 0;
    go_real = 1'b1; sweep_go = 1'b1;
    @(negedge clk);
    sweep_go = 1'b0; go_real = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    #1 chk_idle("mid-sweep reset");
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    #1 chk_idle("after mid-sweep reset");
    run_sweep(0, 12, 12, 3, 1'b0, 1'b0, "R1");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule